// File: doc/BRIEF.md
# Serial Bus Command Frame Encoder

This block turns one slave access request into a command frame for a two-wire serial slave-access bus. A request carries a 2-bit slave ID, a 21-bit byte address, a transfer size of one, two or four bytes, a read/write flag and up to four bytes of write data. The encoder keeps a record of the last address that completed successfully. It uses that record to choose the shortest address form. When the word repeats on the same slave, it uses the same-address form. When the target lies within a short signed distance of the recorded word, it uses the relative form. In every other case it falls back to the absolute form. A separate request type builds the short dead-poll frame that is used to re-query a busy slave.

The fields are packed most significant bit first, and a 4-bit CRC is appended. The finished frame is returned left-aligned in a 64-bit word, together with its bit count. The CRC is computed serially, one bit per clock, behind a start/done handshake. The response logic outside the block reports each outcome on two pulse inputs: a good response, or an error, where an error covers a CRC error or an error acknowledge. These pulses keep the address record current.

Top module: `serial_frame_encoder`

## Requirements
- R1: After a synchronous reset, busy_o and done_o are 0, frame_o and len_o are 0, and the address record is invalid, so the first access frame uses the absolute form.
- R2: An access frame carries, in this order: the slave ID (2 bits), the opcode, a direction bit (1 = read, 0 = write), the address field, a size bit, the write data, and the 4-bit CRC. The absolute form uses opcode 3'b100 with all 21 address bits.
- R3: size_i encodes the transfer size: 0 = one byte, 1 = two bytes, 2 or 3 = four bytes. For one byte, the size bit is 0 and the address field is unchanged. For two bytes, the size bit is 1 and field bit 0 is forced to 0. For four bytes, the size bit is 1 and field bits 1:0 are forced to 2'b01.
- R4: A write carries its data bytes in ascending byte-index order, byte i being wdata_i[8i+7:8i] sent MSB first, one byte per transferred byte. A read carries no data.
- R5: The relative form (opcode 3'b101) carries a 9-bit two's-complement offset, taken from the target byte address minus the recorded word address. It is used when the record is valid, the slave ID matches the record, and the offset lies in -256..+255.
- R6: The same-address form (2-bit opcode 2'b11) carries only the 2 low address bits. It is used when the record is valid, the slave ID matches, and address bits 20:2 equal the recorded word. It wins over the relative form.
- R7: With poll_i set, the frame is the slave ID, opcode 3'b010 and the CRC, 9 bits in total. Such a request does not alter the address record.
- R8: The CRC uses the polynomial x^4+x^2+x+1. The register starts from zero and is fed an implicit leading 1 followed by every frame bit before the CRC, MSB first. Running the same computation over the start bit and the whole frame, CRC included, leaves zero.
- R9: The first frame bit sits at frame_o[63], len_o gives the number of valid bits, and every frame_o bit below the frame is 0.
- R10: A resp_ok_i pulse makes the record valid, holding the slave ID and the word address (address bits 20:2) of the last accepted access request. A resp_err_i pulse makes it invalid, and the error wins when both pulses arrive in the same cycle.
- R11: start_i is taken in a cycle where busy_o is 0. busy_o is then 1 until done_o, which is a one-cycle pulse exactly len_o-2 clock edges after the accepting edge. frame_o and len_o hold until the next done_o.
- R12: While busy_o is 1, start_i and the request inputs have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request strobe, taken when idle |
| poll_i | input | 1 | 1 = dead-poll frame, 0 = access frame |
| read_i | input | 1 | 1 = read access, 0 = write access |
| id_i | input | 2 | Slave ID |
| addr_i | input | 21 | Byte address |
| size_i | input | 2 | Transfer size code |
| wdata_i | input | 32 | Write data, byte i in bits 8i+7:8i |
| resp_ok_i | input | 1 | Last access completed successfully |
| resp_err_i | input | 1 | Last access failed (CRC error or error acknowledge) |
| busy_o | output | 1 | Frame under construction |
| done_o | output | 1 | One-cycle pulse, frame_o and len_o valid |
| frame_o | output | 64 | Left-aligned frame |
| len_o | output | 7 | Number of valid frame bits |

## Verification
The bench builds the encoder with its default parameters: a 2-bit ID, a 21-bit address, a 9-bit relative field, four data bytes and a 64-bit frame. With these values a four-byte absolute write fills all 64 frame bits exactly, which tests the upper edge of the packing and of the length count. The sequence of requests walks the address record through its transitions. It reaches both relative limits, -256 and +255, and the offsets just outside them, +257 and +260. It also covers an ID change, an invalidation, a dead-poll frame that leaves the record alone, and a simultaneous good and error response.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  typedef enum logic [1:0] {
    FORM_ABS  = 2'd0,
    FORM_REL  = 2'd1,
    FORM_SAME = 2'd2,
    FORM_POLL = 2'd3
  } form_e;

  localparam logic [2:0] OPC_ABS  = 3'b100;
  localparam logic [2:0] OPC_REL  = 3'b101;
  localparam logic [2:0] OPC_POLL = 3'b010;
  localparam logic [1:0] OPC_SAME = 2'b11;

  // one serial step of the x^4+x^2+x+1 register
  function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b);
    logic fb;
    fb = b ^ c[3];
    return {c[2:0], 1'b0} ^ (fb ? 4'b0111 : 4'b0000);
  endfunction

endpackage

// File: rtl/sfe_addr_record.sv
module sfe_addr_record #(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 21,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_i,
  input  logic [ID_W-1:0]   cap_id_i,
  input  logic [WORD_W-1:0] cap_word_i,
  input  logic              ok_i,
  input  logic              err_i,
  output logic              valid_o,
  output logic [ID_W-1:0]   id_o,
  output logic [WORD_W-1:0] word_o
);

  logic [ID_W-1:0]   pend_id;
  logic [WORD_W-1:0] pend_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_id   <= '0;
      pend_word <= '0;
      valid_o   <= 1'b0;
      id_o      <= '0;
      word_o    <= '0;
    end else begin
      if (cap_i) begin
        pend_id   <= cap_id_i;
        pend_word <= cap_word_i;
      end
      if (err_i) begin
        valid_o <= 1'b0;
      end else if (ok_i) begin
        valid_o <= 1'b1;
        id_o    <= pend_id;
        word_o  <= pend_word;
      end
    end
  end

  AST_ERR_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
    err_i |=> !valid_o); // R10

  AST_OK_VALIDATES: assert property (@(posedge clk) disable iff (rst)
    (ok_i && !err_i) |=> valid_o); // R10

endmodule

// File: rtl/sfe_form_sel.sv
module sfe_form_sel
  import sfe_pkg::*;
#(
  parameter int ID_W   = 2,
  parameter int ADDR_W = 21,
  parameter int REL_W  = 9,
  parameter int LEN_W  = 7,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              poll_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              rec_valid_i,
  input  logic [ID_W-1:0]   rec_id_i,
  input  logic [WORD_W-1:0] rec_word_i,
  output form_e             form_o,
  output logic [ADDR_W-1:0] fld_o,
  output logic [LEN_W-1:0]  fld_w_o,
  output logic              ds_o
);

  localparam logic signed [ADDR_W:0] REL_HI = (ADDR_W+1)'((1 << (REL_W-1)) - 1);
  localparam logic signed [ADDR_W:0] REL_LO = -REL_HI - 1;

  logic signed [ADDR_W:0] offset;
  logic                   id_match, same_hit, rel_hit;
  logic [ADDR_W-1:0]      raw;

  always_comb begin
    offset   = $signed({1'b0, addr_i}) - $signed({1'b0, rec_word_i, 2'b00});
    id_match = rec_valid_i && (rec_id_i == id_i);
    same_hit = id_match && (rec_word_i == addr_i[ADDR_W-1:2]);
    rel_hit  = id_match && (offset >= REL_LO) && (offset <= REL_HI);

    if (poll_i)        form_o = FORM_POLL;
    else if (same_hit) form_o = FORM_SAME;
    else if (rel_hit)  form_o = FORM_REL;
    else               form_o = FORM_ABS;

    raw = (form_o == FORM_REL) ? offset[ADDR_W-1:0] : addr_i;
    unique case (size_i)
      2'd0:    fld_o = raw;
      2'd1:    fld_o = {raw[ADDR_W-1:1], 1'b0};
      default: fld_o = {raw[ADDR_W-1:2], 2'b01};
    endcase
    ds_o = (size_i != 2'd0);

    unique case (form_o)
      FORM_ABS:  fld_w_o = LEN_W'(ADDR_W);
      FORM_REL:  fld_w_o = LEN_W'(REL_W);
      FORM_SAME: fld_w_o = LEN_W'(2);
      default:   fld_w_o = '0;
    endcase
  end

endmodule

// File: rtl/sfe_packer.sv
module sfe_packer
  import sfe_pkg::*;
#(
  parameter int ID_W       = 2,
  parameter int ADDR_W     = 21,
  parameter int DATA_BYTES = 4,
  parameter int FRAME_W    = 64,
  parameter int LEN_W      = 7
) (
  input  form_e                     form_i,
  input  logic [ID_W-1:0]           id_i,
  input  logic                      rd_i,
  input  logic [ADDR_W-1:0]         fld_i,
  input  logic [LEN_W-1:0]          fld_w_i,
  input  logic                      ds_i,
  input  logic [LEN_W-1:0]          nbytes_i,
  input  logic [8*DATA_BYTES-1:0]   wdata_i,
  output logic [FRAME_W-1:0]        body_o,
  output logic [LEN_W-1:0]          len_o
);

  logic [FRAME_W-1:0] acc;
  logic [LEN_W-1:0]   n;

  always_comb begin
    acc = FRAME_W'(id_i);
    n   = LEN_W'(ID_W);
    if (form_i == FORM_POLL) begin
      acc = (acc << 3) | FRAME_W'(OPC_POLL);
      n   = n + LEN_W'(3);
    end else begin
      unique case (form_i)
        FORM_SAME: begin
          acc = (acc << 2) | FRAME_W'(OPC_SAME);
          n   = n + LEN_W'(2);
        end
        FORM_REL: begin
          acc = (acc << 3) | FRAME_W'(OPC_REL);
          n   = n + LEN_W'(3);
        end
        default: begin
          acc = (acc << 3) | FRAME_W'(OPC_ABS);
          n   = n + LEN_W'(3);
        end
      endcase
      acc = (acc << 1) | FRAME_W'(rd_i);
      n   = n + LEN_W'(1);
      acc = (acc << fld_w_i) | (FRAME_W'(fld_i) & ((FRAME_W'(1) << fld_w_i) - FRAME_W'(1)));
      n   = n + fld_w_i;
      acc = (acc << 1) | FRAME_W'(ds_i);
      n   = n + LEN_W'(1);
      for (int i = 0; i < DATA_BYTES; i++) begin
        if (!rd_i && (LEN_W'(i) < nbytes_i)) begin
          acc = (acc << 8) | FRAME_W'(wdata_i[8*i +: 8]);
          n   = n + LEN_W'(8);
        end
      end
    end
    body_o = acc << (LEN_W'(FRAME_W) - n);
    len_o  = n;
  end

endmodule

// File: rtl/sfe_crc4.sv
module sfe_crc4
  import sfe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [3:0] crc_o
);

  always_ff @(posedge clk) begin
    if (rst || clr_i) crc_o <= 4'h0;
    else if (en_i)    crc_o <= crc4_step(crc_o, bit_i);
  end

  AST_CRC_CLEARED: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (crc_o == 4'h0)); // R8

endmodule

// File: rtl/serial_frame_encoder.sv
module serial_frame_encoder
  import sfe_pkg::*;
#(
  parameter int ID_W       = 2,
  parameter int ADDR_W     = 21,
  parameter int REL_W      = 9,
  parameter int DATA_BYTES = 4,
  parameter int FRAME_W    = 64,
  localparam int LEN_W     = $clog2(FRAME_W + 1),
  localparam int WORD_W    = ADDR_W - 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic                    poll_i,
  input  logic                    read_i,
  input  logic [ID_W-1:0]         id_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [1:0]              size_i,
  input  logic [8*DATA_BYTES-1:0] wdata_i,
  input  logic                    resp_ok_i,
  input  logic                    resp_err_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [FRAME_W-1:0]      frame_o,
  output logic [LEN_W-1:0]        len_o
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_e;

  state_e             state;
  logic               accept;
  logic               rec_valid;
  logic [ID_W-1:0]    rec_id;
  logic [WORD_W-1:0]  rec_word;
  form_e              form;
  logic [ADDR_W-1:0]  fld;
  logic [LEN_W-1:0]   fld_w, nbytes, body_len, blen_q, remain;
  logic               ds;
  logic [FRAME_W-1:0] body, body_q, shreg;
  logic [3:0]         crc;

  assign accept = start_i && (state == S_IDLE);
  assign busy_o = (state != S_IDLE);

  always_comb begin
    unique case (size_i)
      2'd0:    nbytes = LEN_W'(1);
      2'd1:    nbytes = LEN_W'(2);
      default: nbytes = LEN_W'(4);
    endcase
  end

  sfe_addr_record #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_rec (
    .clk        (clk),
    .rst        (rst),
    .cap_i      (accept && !poll_i),
    .cap_id_i   (id_i),
    .cap_word_i (addr_i[ADDR_W-1:2]),
    .ok_i       (resp_ok_i),
    .err_i      (resp_err_i),
    .valid_o    (rec_valid),
    .id_o       (rec_id),
    .word_o     (rec_word)
  );

  sfe_form_sel #(.ID_W(ID_W), .ADDR_W(ADDR_W), .REL_W(REL_W), .LEN_W(LEN_W)) u_sel (
    .poll_i      (poll_i),
    .id_i        (id_i),
    .addr_i      (addr_i),
    .size_i      (size_i),
    .rec_valid_i (rec_valid),
    .rec_id_i    (rec_id),
    .rec_word_i  (rec_word),
    .form_o      (form),
    .fld_o       (fld),
    .fld_w_o     (fld_w),
    .ds_o        (ds)
  );

  sfe_packer #(.ID_W(ID_W), .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES),
               .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_pack (
    .form_i   (form),
    .id_i     (id_i),
    .rd_i     (read_i),
    .fld_i    (fld),
    .fld_w_i  (fld_w),
    .ds_i     (ds),
    .nbytes_i (nbytes),
    .wdata_i  (wdata_i),
    .body_o   (body),
    .len_o    (body_len)
  );

  sfe_crc4 u_crc (
    .clk   (clk),
    .rst   (rst),
    .clr_i (accept),
    .en_i  (state == S_RUN),
    .bit_i (shreg[FRAME_W-1]),
    .crc_o (crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      body_q  <= '0;
      blen_q  <= '0;
      shreg   <= '0;
      remain  <= '0;
      done_o  <= 1'b0;
      frame_o <= '0;
      len_o   <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          body_q <= body;
          blen_q <= body_len;
          shreg  <= {1'b1, body[FRAME_W-1:1]};
          remain <= body_len + LEN_W'(1);
          state  <= S_RUN;
        end
        S_RUN: begin
          shreg  <= shreg << 1;
          remain <= remain - LEN_W'(1);
          if (remain == LEN_W'(1)) state <= S_FIN;
        end
        default: begin
          frame_o <= body_q | ({crc, {(FRAME_W-4){1'b0}}} >> blen_q);
          len_o   <= blen_q + LEN_W'(4);
          done_o  <= 1'b1;
          state   <= S_IDLE;
        end
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R11

  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o); // R11

  AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((frame_o << len_o) == '0)); // R9

  AST_LEN_BOUNDS: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (len_o >= LEN_W'(9) && len_o <= LEN_W'(FRAME_W))); // R9

  AST_BUSY_HOLDS_JOB: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(blen_q) && $stable(body_q)); // R12

endmodule

// File: tb/tb_serial_frame_encoder.sv
module tb_serial_frame_encoder;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i, poll_i, read_i, resp_ok_i, resp_err_i;
  logic [1:0]  id_i, size_i;
  logic [20:0] addr_i;
  logic [31:0] wdata_i;
  logic        busy_o, done_o;
  logic [63:0] frame_o;
  logic [6:0]  len_o;

  always #4 clk = ~clk; // 125 MHz

  serial_frame_encoder dut (
    .clk(clk), .rst(rst), .start_i(start_i), .poll_i(poll_i), .read_i(read_i),
    .id_i(id_i), .addr_i(addr_i), .size_i(size_i), .wdata_i(wdata_i),
    .resp_ok_i(resp_ok_i), .resp_err_i(resp_err_i), .busy_o(busy_o),
    .done_o(done_o), .frame_o(frame_o), .len_o(len_o)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench-side forms: 0 abs, 1 rel, 2 same, 3 poll
  typedef struct packed {
    logic        poll;
    logic        rd;
    logic [1:0]  id;
    logic [20:0] addr;
    logic [1:0]  size;
    logic [31:0] wd;
    logic [1:0]  resp;   // 0 none, 1 ok, 2 err
    logic [1:0]  form;
    logic [6:0]  len;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd3, 21'h000010, 2'd2, 32'h11223344, 2'd1, 2'd0, 7'd64},
    '{1'b0, 1'b1, 2'd3, 21'h000010, 2'd2, 32'h0,        2'd1, 2'd2, 7'd12},
    '{1'b0, 1'b1, 2'd3, 21'h000013, 2'd0, 32'h0,        2'd1, 2'd2, 7'd12},
    '{1'b0, 1'b1, 2'd3, 21'h00010F, 2'd0, 32'h0,        2'd1, 2'd1, 7'd20},
    '{1'b0, 1'b1, 2'd3, 21'h00000C, 2'd1, 32'h0,        2'd1, 2'd1, 7'd20},
    '{1'b0, 1'b1, 2'd3, 21'h000110, 2'd2, 32'h0,        2'd2, 2'd0, 7'd32},
    '{1'b0, 1'b1, 2'd3, 21'h000110, 2'd2, 32'h0,        2'd1, 2'd0, 7'd32},
    '{1'b0, 1'b1, 2'd1, 21'h000110, 2'd2, 32'h0,        2'd0, 2'd0, 7'd32},
    '{1'b1, 1'b1, 2'd2, 21'h000000, 2'd0, 32'h0,        2'd0, 2'd3, 7'd9},
    '{1'b0, 1'b0, 2'd3, 21'h000112, 2'd1, 32'h0000BEEF, 2'd1, 2'd2, 7'd28},
    '{1'b0, 1'b0, 2'd3, 21'h000100, 2'd0, 32'h000000A5, 2'd1, 2'd1, 7'd28},
    '{1'b0, 1'b1, 2'd3, 21'h000201, 2'd0, 32'h0,        2'd1, 2'd0, 7'd32},
    '{1'b0, 1'b0, 2'd0, 21'h1FFFFF, 2'd2, 32'hDEADBEEF, 2'd1, 2'd0, 7'd64},
    '{1'b0, 1'b1, 2'd0, 21'h1FFFFE, 2'd1, 32'h0,        2'd1, 2'd2, 7'd12}
  };

  // bench model state
  logic [63:0] mf;
  int          mp;
  logic [20:0] b_rec_addr, b_pend_addr;

  task automatic put(input logic [31:0] v, input int w);
    for (int k = w - 1; k >= 0; k--) begin
      mf[63 - mp] = v[k];
      mp++;
    end
  endtask

  function automatic logic [20:0] fold(input logic [20:0] v, input logic [1:0] s);
    if (s == 2'd0)      return v;
    else if (s == 2'd1) return {v[20:1], 1'b0};
    else                return {v[20:2], 2'b01};
  endfunction

  // remainder of (1, bits[63..64-n], zeros) divided by 10111
  function automatic logic [3:0] divrem(input logic [63:0] bits, input int n, input int zeros);
    logic [4:0] r;
    r = 5'b00001;
    for (int k = 0; k < n + zeros; k++) begin
      r = {r[3:0], (k < n) ? bits[63 - k] : 1'b0};
      if (r[4]) r = r ^ 5'b10111;
    end
    return r[3:0];
  endfunction

  task automatic build(input vec_t v);
    int nb;
    logic [20:0] off;
    mf = '0; mp = 0;
    nb = (v.size == 2'd0) ? 1 : (v.size == 2'd1) ? 2 : 4;
    put(32'(v.id), 2);
    if (v.form == 2'd3) begin
      put(32'b010, 3);
    end else begin
      if (v.form == 2'd2)      put(32'b11, 2);
      else if (v.form == 2'd1) put(32'b101, 3);
      else                     put(32'b100, 3);
      put(32'(v.rd), 1);
      off = v.addr - b_rec_addr;
      if (v.form == 2'd0)      put(32'(fold(v.addr, v.size)), 21);
      else if (v.form == 2'd1) put(32'(fold(off, v.size)), 9);
      else                     put(32'(fold(v.addr, v.size)), 2);
      put(32'(v.size != 2'd0), 1);
      if (!v.rd) for (int i = 0; i < nb; i++) put(32'(v.wd[8*i +: 8]), 8);
    end
    put(32'(divrem(mf, mp, 4)), 4);
  endtask

  int cyc;

  task automatic launch(input vec_t v);
    @(negedge clk);
    poll_i = v.poll; read_i = v.rd; id_i = v.id; addr_i = v.addr;
    size_i = v.size; wdata_i = v.wd; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
  endtask

  task automatic finish_wait(input vec_t v, input string tag);
    while (!done_o && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    build(v);
    chk(frame_o == mf, {tag, " R2 R3 R4 R5 R6 R7 frame"}, frame_o, mf);
    chk(len_o == v.len, {tag, " R9 length"}, 64'(len_o), 64'(v.len));
    chk(cyc == int'(v.len) - 2, {tag, " R11 latency"}, 64'(cyc), 64'(int'(v.len) - 2));
    chk(divrem(frame_o, int'(len_o), 0) == 4'h0, {tag, " R8 residue"},
        64'(divrem(frame_o, int'(len_o), 0)), 64'h0);
    if (!v.poll) b_pend_addr = {v.addr[20:2], 2'b00};
    if (v.resp == 2'd1) begin resp_ok_i = 1'b1; b_rec_addr = b_pend_addr; end
    if (v.resp == 2'd2) resp_err_i = 1'b1;
    @(negedge clk);
    resp_ok_i = 1'b0; resp_err_i = 1'b0;
    chk(!done_o, {tag, " R11 done single cycle"}, 64'(done_o), 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    vec_t v, w;
    rst = 1'b1; start_i = 0; poll_i = 0; read_i = 0; id_i = 0; addr_i = 0;
    size_i = 0; wdata_i = 0; resp_ok_i = 0; resp_err_i = 0;
    b_rec_addr = '0; b_pend_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o, "R1 reset handshake", {62'h0, busy_o, done_o}, 64'h0);
    chk(frame_o == '0 && len_o == '0, "R1 reset outputs", frame_o, 64'h0);

    // R1: record invalid, id 0 word 0 must still give the absolute form
    v = '{1'b0, 1'b1, 2'd0, 21'h000000, 2'd2, 32'h0, 2'd0, 2'd0, 7'd32};
    launch(v);
    finish_wait(v, "R1 first access absolute");

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i]);
      chk(busy_o, "R11 busy after accept", 64'(busy_o), 64'h1);
      finish_wait(VECS[i], $sformatf("vec%0d", i));
    end

    // R12: start pulses during busy are ignored
    v = '{1'b0, 1'b0, 2'd2, 21'h0ABCDE, 2'd0, 32'h0000005A, 2'd0, 2'd0, 7'd40};
    w = '{1'b1, 1'b1, 2'd1, 21'h000004, 2'd1, 32'hFFFFFFFF, 2'd0, 2'd3, 7'd9};
    launch(v);
    poll_i = w.poll; read_i = w.rd; id_i = w.id; addr_i = w.addr;
    size_i = w.size; wdata_i = w.wd; start_i = 1'b1;
    @(negedge clk); cyc++;
    @(negedge clk); cyc++;
    start_i = 1'b0;
    finish_wait(v, "R12 start while busy");

    // R10: ok and err together, error wins -> absolute form
    v = '{1'b0, 1'b1, 2'd2, 21'h0ABCDC, 2'd2, 32'h0, 2'd0, 2'd2, 7'd12};
    resp_ok_i = 1'b1; resp_err_i = 1'b1;
    @(negedge clk);
    resp_ok_i = 1'b0; resp_err_i = 1'b0;
    v.form = 2'd0; v.len = 7'd32;
    launch(v);
    finish_wait(v, "R10 error wins over ok");

    // R10: ok restores record of last access (id2 word of 0x0ABCDC)
    resp_ok_i = 1'b1;
    @(negedge clk);
    resp_ok_i = 1'b0;
    b_rec_addr = 21'h0ABCDC;
    v.form = 2'd2; v.len = 7'd12;
    launch(v);
    finish_wait(v, "R10 ok revalidates");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule